// File: doc/BRIEF.md
# Multi-Slope Code Linearizer

This block turns the raw count of a multi-slope single-slope conversion into a linear code expressed in the finest-resolution LSB. The ramp is built from several segments whose slopes differ by powers of two, so each segment contributes its steps scaled by a left shift. The segment boundaries (knees) are programmed as raw-count positions, and each segment is given a bit depth from which its shift is derived.

Because the conversion datapath has a delay, the slope change is seen later than programmed. Each column therefore keeps a small table of measured delay coefficients, one per segment. When correction is enabled, every knee is moved later by the coefficient of the segment that the knee opens, before the block works out which segment a count falls into. With correction disabled, the nominal knees are used. A conversion enters with a column index and a valid strobe. Three clock cycles later, the linear code leaves with its own valid strobe. Results that exceed the output range are clipped to the largest code.

Top module: `msl_linearizer`

## Requirements
- R1: A conversion accepted with `in_valid` high at a rising edge produces `out_valid` high exactly three rising edges later, and `out_valid` is low in every other cycle.
- R2: A raw count below the first nominal knee is output unchanged.
- R3: Knee k (k = 0 upward, packed at bits k*CNT_W of `cfg_knee`, ascending) is the first raw count of segment k+1. A count equal to its (corrected) knee already belongs to the later segment.
- R4: Segment j takes its bit depth from bits j*5 of `cfg_depth`, and its weight is 2^(14 - depth). The output is the sum, over all earlier segments, of each segment's full width times its weight, plus the count's offset into its own segment times that segment's weight.
- R5: With `corr_en` high, knee k is moved later by the delay coefficient stored for segment k+1 of the conversion's column.
- R6: With `corr_en` low, the stored coefficients have no effect and the nominal knees apply.
- R7: A coefficient written with `coef_we` for column c and segment j affects only conversions of column c. The write takes effect for conversions accepted after the edge that stores it.
- R8: A result larger than 2^OUT_W - 1 is output as 2^OUT_W - 1.
- R9: After reset, `out_valid` and `out_code` are zero and every stored coefficient is zero.
- R10: `out_code` holds its last value in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| corr_en | input | 1 | Apply delay correction to the knees of this conversion |
| cfg_knee | input | (NSEG-1)*CNT_W | Nominal knee positions, knee k at bits k*CNT_W |
| cfg_depth | input | NSEG*5 | Segment bit depths, segment j at bits j*5 |
| coef_we | input | 1 | Write strobe for one delay coefficient |
| coef_col | input | log2(NCOL) | Column of the coefficient written |
| coef_seg | input | log2(NSEG) | Segment of the coefficient written |
| coef_dly | input | DLY_W | Delay value in raw counts |
| in_valid | input | 1 | Raw count present |
| in_raw | input | CNT_W | Raw conversion count |
| in_col | input | log2(NCOL) | Column the count belongs to |
| out_valid | output | 1 | Linear code present |
| out_code | output | OUT_W | Linear code in finest LSB units |

## Verification
A corrupted coefficient table entry or a wrong segment index only becomes visible for counts at or above the affected knee. Counts below it come out correct, so the stimulus places counts on both sides of every corrected knee and in more than one column. A wrong segment choice appears as a jump of one weight step in the output, three cycles after the count was accepted. A wrong accumulated base shifts every code in the later segments by the same amount. A valid strobe that slips by one stage breaks the fixed latency, which shows up on the first conversion after any idle gap.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int DEP_W = 5;

  // Scale a span of raw steps by a power-of-two slope ratio.
  function automatic logic [31:0] shl_weight(input logic [31:0] span, input logic [DEP_W-1:0] sh);
    return span << sh;
  endfunction

  // Shift of a segment relative to the finest depth; clipped at zero.
  function automatic logic [DEP_W-1:0] depth_shift(input logic [DEP_W-1:0] finest,
                                                   input logic [DEP_W-1:0] depth);
    return (depth > finest) ? '0 : finest - depth;
  endfunction
endpackage

// File: rtl/msl_coef_store.sv
module msl_coef_store #(
  parameter int NCOL  = 16,
  parameter int NSEG  = 5,
  parameter int DLY_W = 8,
  localparam int COL_W = $clog2(NCOL),
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [COL_W-1:0]      wr_col,
  input  logic [SEG_W-1:0]      wr_seg,
  input  logic [DLY_W-1:0]      wr_dly,
  input  logic [COL_W-1:0]      rd_col,
  output logic [NSEG*DLY_W-1:0] rd_dly
);
  logic [NSEG*DLY_W-1:0] row_q [NCOL];

  generate
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            row_q[c][s*DLY_W +: DLY_W] <= '0;
          else if (wr_en && (wr_col == COL_W'(c)) && (wr_seg == SEG_W'(s)))
            row_q[c][s*DLY_W +: DLY_W] <= wr_dly;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_dly <= '0;
    else        rd_dly <= row_q[rd_col];
  end
endmodule

// File: rtl/msl_knee_locate.sv
module msl_knee_locate import msl_pkg::*; #(
  parameter int CNT_W      = 12,
  parameter int NSEG       = 5,
  parameter int DLY_W      = 8,
  parameter int BASE_DEPTH = 14,
  parameter int ACC_W      = 30,
  localparam int SEG_W = $clog2(NSEG),
  localparam int KNE_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]          raw,
  input  logic                      corr_en,
  input  logic [(NSEG-1)*CNT_W-1:0] knee_nom,
  input  logic [NSEG*DLY_W-1:0]     dly,
  input  logic [NSEG*DEP_W-1:0]     depth,
  output logic [SEG_W-1:0]          seg,
  output logic [ACC_W-1:0]          base,
  output logic [CNT_W-1:0]          offs,
  output logic [DEP_W-1:0]          shift
);
  logic [KNE_W-1:0] start [NSEG];
  logic [DEP_W-1:0] sh    [NSEG];
  logic [KNE_W-1:0] raw_x;

  assign raw_x    = KNE_W'(raw);
  assign start[0] = '0;

  generate
    for (genvar k = 1; k < NSEG; k++) begin : g_knee
      logic [DLY_W-1:0] d_k;
      assign d_k      = corr_en ? dly[k*DLY_W +: DLY_W] : '0;
      assign start[k] = KNE_W'(knee_nom[(k-1)*CNT_W +: CNT_W]) + KNE_W'(d_k);
    end
    for (genvar j = 0; j < NSEG; j++) begin : g_shift
      assign sh[j] = depth_shift(DEP_W'(BASE_DEPTH), depth[j*DEP_W +: DEP_W]);
    end
  endgenerate

  always_comb begin
    seg = '0;
    for (int k = 1; k < NSEG; k++)
      if (raw_x >= start[k]) seg = seg + SEG_W'(1);
    base = '0;
    for (int j = 0; j < NSEG - 1; j++)
      if (SEG_W'(j) < seg)
        base = base + ACC_W'(shl_weight(32'(start[j+1] - start[j]), sh[j]));
    offs  = CNT_W'(raw_x - start[seg]);
    shift = sh[seg];
  end
endmodule

// File: rtl/msl_weigh.sv
module msl_weigh import msl_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int OUT_W = 14,
  parameter int ACC_W = 30
) (
  input  logic [ACC_W-1:0] base,
  input  logic [CNT_W-1:0] offs,
  input  logic [DEP_W-1:0] shift,
  output logic [OUT_W-1:0] code,
  output logic             over
);
  localparam logic [ACC_W-1:0] TOP = {{(ACC_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  logic [ACC_W-1:0] sum;

  assign sum  = base + ACC_W'(shl_weight(32'(offs), shift));
  assign over = sum > TOP;
  assign code = over ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
endmodule

// File: rtl/msl_linearizer.sv
module msl_linearizer import msl_pkg::*; #(
  parameter int CNT_W      = 12,
  parameter int OUT_W      = 14,
  parameter int NSEG       = 5,
  parameter int NCOL       = 16,
  parameter int DLY_W      = 8,
  parameter int BASE_DEPTH = 14,
  localparam int COL_W = $clog2(NCOL),
  localparam int SEG_W = $clog2(NSEG),
  localparam int ACC_W = CNT_W + BASE_DEPTH + SEG_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      corr_en,
  input  logic [(NSEG-1)*CNT_W-1:0] cfg_knee,
  input  logic [NSEG*DEP_W-1:0]     cfg_depth,
  input  logic                      coef_we,
  input  logic [COL_W-1:0]          coef_col,
  input  logic [SEG_W-1:0]          coef_seg,
  input  logic [DLY_W-1:0]          coef_dly,
  input  logic                      in_valid,
  input  logic [CNT_W-1:0]          in_raw,
  input  logic [COL_W-1:0]          in_col,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_code
);
  // Stage 1: capture count, fetch column coefficients
  logic                  s1_v, s1_en;
  logic [CNT_W-1:0]      s1_raw;
  logic [NSEG*DLY_W-1:0] s1_dly;

  msl_coef_store #(.NCOL(NCOL), .NSEG(NSEG), .DLY_W(DLY_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(coef_we), .wr_col(coef_col), .wr_seg(coef_seg), .wr_dly(coef_dly),
    .rd_col(in_col), .rd_dly(s1_dly)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_en <= 1'b0; s1_raw <= '0;
    end else begin
      s1_v <= in_valid; s1_en <= corr_en; s1_raw <= in_raw;
    end
  end

  // Stage 2: correct knees, locate segment, accumulate earlier segments
  logic [SEG_W-1:0] w_seg;
  logic [ACC_W-1:0] w_base;
  logic [CNT_W-1:0] w_offs;
  logic [DEP_W-1:0] w_shift;

  msl_knee_locate #(.CNT_W(CNT_W), .NSEG(NSEG), .DLY_W(DLY_W),
                    .BASE_DEPTH(BASE_DEPTH), .ACC_W(ACC_W)) u_locate (
    .raw(s1_raw), .corr_en(s1_en), .knee_nom(cfg_knee), .dly(s1_dly), .depth(cfg_depth),
    .seg(w_seg), .base(w_base), .offs(w_offs), .shift(w_shift)
  );

  logic             s2_v;
  logic [SEG_W-1:0] s2_seg;
  logic [ACC_W-1:0] s2_base;
  logic [CNT_W-1:0] s2_offs;
  logic [DEP_W-1:0] s2_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_seg <= '0; s2_base <= '0; s2_offs <= '0; s2_shift <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_seg <= w_seg; s2_base <= w_base; s2_offs <= w_offs; s2_shift <= w_shift;
      end
    end
  end

  // Stage 3: weight in-segment offset, add, clip
  logic [OUT_W-1:0] w_code;
  logic             w_over;

  msl_weigh #(.CNT_W(CNT_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_weigh (
    .base(s2_base), .offs(s2_offs), .shift(s2_shift), .code(w_code), .over(w_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_code <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) out_code <= w_code;
    end
  end
endmodule

// File: rtl/msl_linearizer_chk.sv
module msl_linearizer_chk #(
  parameter int CNT_W = 12,
  parameter int OUT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CNT_W-1:0] in_raw,
  input logic [CNT_W-1:0] knee0,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_code,
  input logic             s2_v,
  input logic             w_over
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= '0;
    else if (age != 2'd3)   age <= age + 2'd1;
  end

  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd3) |-> !out_valid);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && ($past(in_raw, 3) < knee0))
      |-> (out_code == OUT_W'($past(in_raw, 3))));

  p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && w_over) |=> (out_code == {OUT_W{1'b1}}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_v |=> $stable(out_code));
endmodule

bind msl_linearizer msl_linearizer_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
  .knee0(cfg_knee[CNT_W-1:0]), .out_valid(out_valid), .out_code(out_code),
  .s2_v(s2_v), .w_over(w_over)
);

// File: tb/msl_linearizer_bench.sv
`timescale 1ns/1ps
module msl_linearizer_bench;
  localparam int CNT_W = 12, OUT_W = 14, NSEG = 5, NCOL = 16, DLY_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, corr_en = 1'b0;
  logic [(NSEG-1)*CNT_W-1:0] cfg_knee = {12'd2200, 12'd1900, 12'd1500, 12'd1000};
  logic [NSEG*5-1:0] cfg_depth = {5'd10, 5'd11, 5'd12, 5'd13, 5'd14};
  logic coef_we = 1'b0;
  logic [3:0] coef_col = '0;
  logic [2:0] coef_seg = '0;
  logic [DLY_W-1:0] coef_dly = '0;
  logic in_valid = 1'b0;
  logic [CNT_W-1:0] in_raw = '0;
  logic [3:0] in_col = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_code;

  always #5 clk = ~clk;

  msl_linearizer u_msl_linearizer (
    .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .cfg_knee(cfg_knee), .cfg_depth(cfg_depth),
    .coef_we(coef_we), .coef_col(coef_col), .coef_seg(coef_seg), .coef_dly(coef_dly),
    .in_valid(in_valid), .in_raw(in_raw), .in_col(in_col),
    .out_valid(out_valid), .out_code(out_code)
  );

  int knee_b[4] = '{1000, 1500, 1900, 2200};
  int dep_b[5]  = '{14, 13, 12, 11, 10};
  int dtab[16][5];
  int nchk = 0, nfail = 0, n = 0, last_code = 0;
  bit rv[4];
  int rc[4];
  string rt[4];

  // Step-by-step model: every raw step adds the weight of the segment it lies in.
  function automatic int ref_code(int raw, int col, bit en);
    int st[5];
    int acc = 0;
    st[0] = 0;
    for (int k = 1; k < 5; k++) st[k] = knee_b[k-1] + (en ? dtab[col][k] : 0);
    for (int i = 0; i < raw; i++) begin
      int s = 0;
      for (int k = 1; k < 5; k++) if (i >= st[k]) s = k;
      acc += (1 << (14 - dep_b[s]));
    end
    return (acc > 16383) ? 16383 : acc;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit v, int raw, int col, bit en, bit we, int wc, int ws, int wd, string tag);
    bit ev;
    @(negedge clk);
    ev = (n >= 3) ? rv[(n+1)%4] : 1'b0;
    chk(out_valid === ev, "R1 valid", int'(out_valid), int'(ev));
    if (ev) begin
      chk(out_code == OUT_W'(rc[(n+1)%4]), rt[(n+1)%4], int'(out_code), rc[(n+1)%4]);
      last_code = rc[(n+1)%4];
    end else begin
      chk(out_code == OUT_W'(last_code), "R10 hold", int'(out_code), last_code);
    end
    in_valid = v; in_raw = CNT_W'(raw); in_col = 4'(col); corr_en = en;
    coef_we = we; coef_col = 4'(wc); coef_seg = 3'(ws); coef_dly = DLY_W'(wd);
    rv[n%4] = v;
    rc[n%4] = v ? ref_code(raw, col, en) : 0;
    rt[n%4] = tag;
    if (we) dtab[wc][ws] = wd;
    n++;
  endtask

  task automatic conv(int raw, int col, bit en, string tag);
    tick(1'b1, raw, col, en, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic idle(int cnt);
    for (int i = 0; i < cnt; i++) tick(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0, "idle");
  endtask

  task automatic wr(int c, int s, int d);
    tick(1'b0, 0, 0, 1'b0, 1'b1, c, s, d, "write");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) for (int s = 0; s < 5; s++) dtab[c][s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
    chk(out_code == '0, "R9 reset code", int'(out_code), 0);
    rst_n = 1'b1;

    // R9: cleared table gives nominal knees even with correction on
    conv(1003, 9, 1'b1, "R9 cleared coef");
    conv(999, 2, 1'b1, "R2 below first knee");
    idle(3);

    wr(0, 1, 70); wr(0, 2, 40); wr(0, 3, 20); wr(0, 4, 10); wr(5, 1, 5);
    // R2 identity region
    conv(0, 0, 1'b1, "R2 zero");
    conv(1, 0, 1'b1, "R2 one");
    conv(999, 0, 1'b0, "R2 bypass below knee");
    // R3/R5 corrected boundaries, column 0
    conv(1069, 0, 1'b1, "R5 before corrected knee0");
    conv(1070, 0, 1'b1, "R3 at corrected knee0");
    conv(1539, 0, 1'b1, "R5 before corrected knee1");
    conv(1540, 0, 1'b1, "R3 at corrected knee1");
    conv(1919, 0, 1'b1, "R5 before corrected knee2");
    conv(1920, 0, 1'b1, "R3 at corrected knee2");
    conv(2210, 0, 1'b1, "R3 at corrected knee3");
    idle(2);
    // R6 bypass ignores table
    conv(1000, 0, 1'b0, "R6 nominal knee0");
    conv(1069, 0, 1'b0, "R6 nominal past knee0");
    conv(1500, 0, 1'b0, "R6 nominal knee1");
    // R7 column isolation
    conv(1003, 5, 1'b1, "R7 col5 delay 5");
    conv(1003, 1, 1'b1, "R7 col1 untouched");
    conv(1005, 5, 1'b1, "R7 col5 at knee");
    wr(0, 2, 0);
    conv(1539, 0, 1'b1, "R7 rewritten coef");
    conv(1539, 1, 1'b1, "R7 other col");
    idle(1);
    // R4 sweep, back to back, alternating correction
    for (int r = 0; r < 4096; r += 97) conv(r, r % 3, bit'(r % 2), "R4 sweep");
    idle(4);
    // R8 clipping
    conv(4095, 0, 1'b1, "R8 max raw");
    conv(2900, 1, 1'b0, "R8 above range");
    conv(2800, 1, 1'b0, "R8 just in range");
    idle(5);
    summary();
    $finish;
  end
endmodule